// File: doc/BRIEF.md
# Converter Control Register and Power-Down Sequencer

This block is the digital control core of a sampling converter. It holds an 8-bit control and status register and sequences the converter's operating modes around it. A host reaches the register over a small parallel bus with an active-low chip select, an active-low write strobe, an active-low read strobe and two select lines (register select and high-byte enable). The block never performs a conversion or calibration itself. It issues one-cycle request pulses to an abstracted engine. That engine answers with a done strobe, and with an overflow strobe when a calibration overflows.

Power-down is a sequenced state rather than a simple sleep bit. While sleeping, a bus write with register select low wakes the clock for exactly one conversion and then lets it sleep again. A register write that sets the calibrate and power-down bits together runs a calibration, then one conversion, and then returns to sleep. A supply-fail pulse clears the mode bits, sets a sticky failure flag and forces a calibration, even if a sequence is already running. The clock-gate output models the converter's power state.

Top module: `adc_ctl_core`

## Requirements
- R1: After reset the status reads 0x00, the clock-gate enable is 1 and neither request output is high.
- R2: A read returns status only while chip select and read strobe are low and register select and high-byte enable are both high. The status bits are: bit7 busy, bit6 calibration overflow error, bit5 supply-fail flag, bit4 always 0, bit3 power-down, bit2 trigger-pin mode, bit1 calibration running, bit0 output-latch mode (1 = latched). Every other read, including register select high with high-byte enable low, returns 0x00.
- R3: A register write is taken once, in the first clock cycle in which chip select and write strobe are both low with both select lines high. It loads bits 0, 2 and 3 from the data. A write with high-byte enable low changes nothing. Data bits 4 and 6 are ignored.
- R4: With bit3 at 1 and no sequence active, the clock-gate enable is 0. Writing bit3 = 0 raises it again.
- R5: The first cycle of a bus write with register select low starts one conversion: conv_req pulses, busy reads 1 and the clock gate is enabled. On engine done the block returns to idle, and if bit3 is 1 the clock gate drops to 0 again.
- R6: Writing bit1 = 1 with bit3 = 0 starts a calibration: cal_req pulses, bits 7 and 1 read 1, and bit3 is cleared.
- R7: Writing bit1 = 1 and bit3 = 1 together starts a calibration. Its done strobe pulses conv_req in the next cycle. After the conversion's done strobe the block is idle with bit3 = 1 and the clock gate at 0.
- R8: A falling edge on the active-low calibration pin starts a calibration and clears bit3.
- R9: A supply-fail pulse clears bits 0, 2 and 3, sets bit5 and starts a calibration, aborting any running sequence.
- R10: Writing bit5 = 0 clears the supply-fail flag. Writing bit5 = 1 leaves it unchanged.
- R11: An overflow strobe during a calibration sets bit6. The start of the next calibration clears it.
- R12: Start requests that arrive while busy are ignored (no request pulse, no new sequence), but mode bits in such a write still update. cal_req and conv_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_regsel | input | 1 | Register select (1 = control register, 0 = conversion command) |
| bus_hbe | input | 1 | High-byte enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, status when selected, else zero |
| cal_pin_n | input | 1 | Calibration request pin, falling edge starts calibration |
| supply_fail | input | 1 | One-cycle supply failure pulse |
| eng_done | input | 1 | Engine done strobe for the current calibration or conversion |
| eng_ovf | input | 1 | Engine overflow strobe during calibration |
| cal_req | output | 1 | One-cycle calibration start request |
| conv_req | output | 1 | One-cycle conversion start request |
| clk_en | output | 1 | Converter clock-gate enable (0 = powered down) |

## Verification
A wrong sequencer state shows at the ports within one cycle. It appears as a request pulse that should be absent, as busy or calibration bits that disagree with the requests issued, or as a clock gate that stays low during a wake-up conversion. A corrupted register bit shows on the next qualified read. A lost chain flag shows as a missing conv_req on the cycle after the calibration's done strobe. A stuck overflow or supply-fail flag shows at the next calibration start or the next clearing write.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned B_LATCH = 0;
  localparam int unsigned B_CAL   = 1;
  localparam int unsigned B_TRIG  = 2;
  localparam int unsigned B_PDN   = 3;
  localparam int unsigned B_PF    = 5;
  localparam int unsigned B_CERR  = 6;
  localparam int unsigned B_BUSY  = 7;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CAL  = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic latched;
    logic trig;
    logic pdn;
    logic pf;
    logic cal_err;
  } ctl_regs_t;

  // Build the status byte from stored fields and live sequencer state.
  function automatic logic [REG_W-1:0] pack_status(ctl_regs_t r, logic in_cal, logic busy);
    logic [REG_W-1:0] s;
    s = '0;
    s[B_LATCH] = r.latched;
    s[B_CAL]   = in_cal;
    s[B_TRIG]  = r.trig;
    s[B_PDN]   = r.pdn;
    s[B_PF]    = r.pf;
    s[B_CERR]  = r.cal_err;
    s[B_BUSY]  = busy;
    return s;
  endfunction

  // The converter clock runs unless sleeping with nothing in flight.
  function automatic logic gate_on(logic pdn, logic busy);
    return !(pdn && !busy);
  endfunction
endpackage

// File: rtl/adc_ctl_busif.sv
module adc_ctl_busif (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  input  logic regsel,
  input  logic hbe,
  input  logic cal_pin_n,
  output logic reg_wr_evt,
  output logic conv_wr_evt,
  output logic reg_rd_en,
  output logic cal_pin_evt
);
  logic wr_act, wr_act_q, wr_first, reg_hit, cal_pin_q;

  assign wr_act   = !cs_n && !wr_n;
  assign wr_first = wr_act && !wr_act_q;
  assign reg_hit  = regsel && hbe;

  assign reg_wr_evt  = wr_first && reg_hit;
  assign conv_wr_evt = wr_first && !regsel;
  assign reg_rd_en   = !cs_n && !rd_n && reg_hit;
  assign cal_pin_evt = !cal_pin_n && cal_pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act_q  <= 1'b0;
      cal_pin_q <= 1'b1;
    end else begin
      wr_act_q  <= wr_act;
      cal_pin_q <= cal_pin_n;
    end
  end
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
  import adc_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reg_wr_evt,
  input  logic      wd_latch,
  input  logic      wd_trig,
  input  logic      wd_pdn,
  input  logic      wd_pf,
  input  logic      cal_pin_evt,
  input  logic      supply_fail,
  input  logic      cal_go,
  input  logic      ovf_evt,
  output ctl_regs_t regs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (supply_fail) begin
      regs.latched <= 1'b0;
      regs.trig    <= 1'b0;
      regs.pdn     <= 1'b0;
      regs.pf      <= 1'b1;
      regs.cal_err <= 1'b0;
    end else begin
      if (reg_wr_evt) begin
        regs.latched <= wd_latch;
        regs.trig    <= wd_trig;
        regs.pdn     <= wd_pdn;
        if (!wd_pf) regs.pf <= 1'b0;
      end
      if (cal_pin_evt) regs.pdn <= 1'b0;
      if (cal_go)       regs.cal_err <= 1'b0;
      else if (ovf_evt) regs.cal_err <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_cal,
  input  logic start_chain,
  input  logic start_conv,
  input  logic force_cal,
  input  logic eng_done,
  input  logic eng_ovf,
  output logic busy,
  output logic in_cal,
  output logic chain,
  output logic cal_go,
  output logic ovf_evt,
  output logic cal_req,
  output logic conv_req
);
  seq_state_t state;
  logic       conv_go, idle;

  assign idle    = (state == SEQ_IDLE);
  assign busy    = !idle;
  assign in_cal  = (state == SEQ_CAL);
  assign cal_go  = force_cal || (idle && start_cal);
  assign conv_go = !force_cal &&
                   ((idle && !start_cal && start_conv) || (in_cal && eng_done && chain));
  assign ovf_evt = in_cal && eng_ovf && !force_cal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      chain    <= 1'b0;
      cal_req  <= 1'b0;
      conv_req <= 1'b0;
    end else begin
      cal_req  <= cal_go;
      conv_req <= conv_go;
      if (force_cal) begin
        state <= SEQ_CAL;
        chain <= 1'b0;
      end else begin
        unique case (state)
          SEQ_IDLE: begin
            if (start_cal) begin
              state <= SEQ_CAL;
              chain <= start_chain;
            end else if (start_conv) begin
              state <= SEQ_CONV;
            end
          end
          SEQ_CAL: begin
            if (eng_done) begin
              state <= chain ? SEQ_CONV : SEQ_IDLE;
              chain <= 1'b0;
            end
          end
          SEQ_CONV: if (eng_done) state <= SEQ_IDLE;
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_ctl_core.sv
module adc_ctl_core
  import adc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs_n,
  input  logic             bus_wr_n,
  input  logic             bus_rd_n,
  input  logic             bus_regsel,
  input  logic             bus_hbe,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             cal_pin_n,
  input  logic             supply_fail,
  input  logic             eng_done,
  input  logic             eng_ovf,
  output logic             cal_req,
  output logic             conv_req,
  output logic             clk_en
);
  logic      reg_wr_evt, conv_wr_evt, reg_rd_en, cal_pin_evt;
  logic      seq_busy, seq_in_cal, seq_chain, cal_go, ovf_evt;
  logic      start_cal, start_chain;
  ctl_regs_t regs;
  logic      unused_wbits;

  assign unused_wbits = ^{bus_wdata[7:6], bus_wdata[4]};

  adc_ctl_busif busif_i (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .wr_n(bus_wr_n), .rd_n(bus_rd_n),
    .regsel(bus_regsel), .hbe(bus_hbe), .cal_pin_n(cal_pin_n),
    .reg_wr_evt(reg_wr_evt), .conv_wr_evt(conv_wr_evt),
    .reg_rd_en(reg_rd_en), .cal_pin_evt(cal_pin_evt)
  );

  assign start_cal   = (reg_wr_evt && bus_wdata[B_CAL]) || cal_pin_evt;
  assign start_chain = reg_wr_evt && bus_wdata[B_CAL] && bus_wdata[B_PDN];

  adc_ctl_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start_cal(start_cal), .start_chain(start_chain),
    .start_conv(conv_wr_evt), .force_cal(supply_fail), .eng_done(eng_done),
    .eng_ovf(eng_ovf), .busy(seq_busy), .in_cal(seq_in_cal), .chain(seq_chain),
    .cal_go(cal_go), .ovf_evt(ovf_evt), .cal_req(cal_req), .conv_req(conv_req)
  );

  adc_ctl_regs regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_evt(reg_wr_evt),
    .wd_latch(bus_wdata[B_LATCH]), .wd_trig(bus_wdata[B_TRIG]),
    .wd_pdn(bus_wdata[B_PDN]), .wd_pf(bus_wdata[B_PF]),
    .cal_pin_evt(cal_pin_evt), .supply_fail(supply_fail),
    .cal_go(cal_go), .ovf_evt(ovf_evt), .regs(regs)
  );

  assign bus_rdata = reg_rd_en ? pack_status(regs, seq_in_cal, seq_busy) : '0;
  assign clk_en    = gate_on(regs.pdn, seq_busy);
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic cal_req,
  input logic conv_req,
  input logic clk_en,
  input logic supply_fail,
  input logic eng_done,
  input logic busy,
  input logic in_cal,
  input logic chain,
  input logic pdn,
  input logic pf,
  input logic cal_err
);
  a_r12_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_req && conv_req));

  a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> (!$past(busy) || $past(supply_fail)));

  a_r9_supply_fail: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail |=> (cal_req && pf && !pdn));

  a_r7_chain_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cal && eng_done && chain && !supply_fail) |=> conv_req);

  a_r5_conv_awake: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (clk_en && busy && !in_cal));

  a_r11_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> (!cal_err && in_cal));
endmodule

bind adc_ctl_core adc_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .conv_req(conv_req),
  .clk_en(clk_en), .supply_fail(supply_fail), .eng_done(eng_done),
  .busy(seq_busy), .in_cal(seq_in_cal), .chain(seq_chain),
  .pdn(regs.pdn), .pf(regs.pf), .cal_err(regs.cal_err)
);

// File: tb/adc_ctl_core_tb.sv
module adc_ctl_core_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, regsel = 1'b0, hbe = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cal_pin_n = 1'b1, supply_fail = 1'b0, eng_done = 1'b0, eng_ovf = 1'b0;
  logic       cal_req, conv_req, clk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctl_core dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
    .bus_regsel(regsel), .bus_hbe(hbe), .bus_wdata(wdata), .bus_rdata(rdata),
    .cal_pin_n(cal_pin_n), .supply_fail(supply_fail), .eng_done(eng_done),
    .eng_ovf(eng_ovf), .cal_req(cal_req), .conv_req(conv_req), .clk_en(clk_en)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic sel, logic be, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; regsel = sel; hbe = be; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(logic sel, logic be, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; regsel = sel; hbe = be;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic read_status(string tag, logic [7:0] exp);
    logic [7:0] v;
    bus_read(1'b1, 1'b1, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    check("R1 clk_en", {7'd0, clk_en}, 8'h01);
    check("R1 reqs", {6'd0, cal_req, conv_req}, 8'h00);
    read_status("R1 status", 8'h00);
  endtask

  task automatic t_map;
    logic [7:0] v;
    bus_write(1'b1, 1'b1, 8'h05);
    read_status("R3 write b0 b2", 8'h05);
    bus_read(1'b1, 1'b0, v);
    check("R2 read hbe low", v, 8'h00);
    bus_read(1'b0, 1'b1, v);
    check("R2 read regsel low", v, 8'h00);
    bus_write(1'b1, 1'b0, 8'h00);
    read_status("R3 write hbe low ignored", 8'h05);
    bus_write(1'b1, 1'b1, 8'h55);
    read_status("R3 bits 4 6 ignored", 8'h05);
    bus_write(1'b1, 1'b1, 8'h00);
    read_status("R2 cleared", 8'h00);
  endtask

  task automatic t_pdn;
    bus_write(1'b1, 1'b1, 8'h08);
    check("R4 sleep gate", {7'd0, clk_en}, 8'h00);
    read_status("R4 pdn bit", 8'h08);
    bus_write(1'b1, 1'b1, 8'h00);
    check("R4 wake gate", {7'd0, clk_en}, 8'h01);
  endtask

  task automatic t_pdn_conv;
    bus_write(1'b1, 1'b1, 8'h08);
    bus_write(1'b0, 1'b0, 8'h00);
    check("R5 conv_req", {7'd0, conv_req}, 8'h01);
    check("R5 gate during conv", {7'd0, clk_en}, 8'h01);
    read_status("R5 busy in sleep", 8'h88);
    pulse(eng_done);
    check("R5 back to sleep", {7'd0, clk_en}, 8'h00);
    read_status("R5 pdn kept", 8'h08);
  endtask

  task automatic t_cal_write;
    bus_write(1'b1, 1'b1, 8'h02);
    check("R6 cal_req", {7'd0, cal_req}, 8'h01);
    check("R6 gate on", {7'd0, clk_en}, 8'h01);
    read_status("R6 cal running pdn cleared", 8'h82);
    bus_write(1'b1, 1'b1, 8'h03);
    check("R12 no cal restart", {7'd0, cal_req}, 8'h00);
    bus_write(1'b0, 1'b0, 8'h00);
    check("R12 no conv while busy", {7'd0, conv_req}, 8'h00);
    read_status("R12 mode bit updated", 8'h83);
    pulse(eng_done);
    read_status("R6 cal finished", 8'h01);
    bus_write(1'b1, 1'b1, 8'h00);
  endtask

  task automatic t_chain;
    bus_write(1'b1, 1'b1, 8'h0A);
    check("R7 cal_req", {7'd0, cal_req}, 8'h01);
    read_status("R7 calibrating", 8'h8A);
    pulse(eng_done);
    check("R7 conv_req after cal", {7'd0, conv_req}, 8'h01);
    check("R7 gate on", {7'd0, clk_en}, 8'h01);
    pulse(eng_done);
    check("R7 asleep", {7'd0, clk_en}, 8'h00);
    read_status("R7 idle pdn", 8'h08);
    bus_write(1'b1, 1'b1, 8'h00);
  endtask

  task automatic t_cal_pin;
    bus_write(1'b1, 1'b1, 8'h08);
    @(negedge clk);
    cal_pin_n = 1'b0;
    @(negedge clk);
    check("R8 cal_req", {7'd0, cal_req}, 8'h01);
    cal_pin_n = 1'b1;
    read_status("R8 pdn cleared", 8'h82);
    pulse(eng_done);
  endtask

  task automatic t_ovf;
    bus_write(1'b1, 1'b1, 8'h02);
    pulse(eng_ovf);
    read_status("R11 err set", 8'hC2);
    pulse(eng_done);
    read_status("R11 err sticky", 8'h40);
    bus_write(1'b1, 1'b1, 8'h02);
    read_status("R11 err cleared on cal", 8'h82);
    pulse(eng_done);
  endtask

  task automatic t_supply;
    bus_write(1'b1, 1'b1, 8'h0D);
    bus_write(1'b0, 1'b0, 8'h00);
    pulse(supply_fail);
    check("R9 cal_req", {7'd0, cal_req}, 8'h01);
    check("R9 gate", {7'd0, clk_en}, 8'h01);
    read_status("R9 reset and cal", 8'hA2);
    pulse(eng_done);
    read_status("R9 flag held", 8'h20);
    bus_write(1'b1, 1'b1, 8'h20);
    read_status("R10 write one keeps", 8'h20);
    bus_write(1'b1, 1'b1, 8'h00);
    read_status("R10 write zero clears", 8'h00);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_pdn();
    t_pdn_conv();
    t_cal_write();
    t_chain();
    t_cal_pin();
    t_ovf();
    t_supply();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule